// File: doc/BRIEF.md
# ADC Conversion Sequencer with Hidden Discard

This block paces a free-running conversion engine. A single register write carries an enable bit and a configuration field. While the block is enabled, it starts conversions back to back with no further software action. It presents each usable result with a one-cycle strobe, together with the configuration field in force for that result.

The block hides the conversions that cannot be trusted. The first conversion after an enable is dropped. So is the first one after any configuration write, and the first one after the system clock moves between the fast crystal source and the slow RC source. When the block leaves the disabled state, an analog settling delay runs first and the dropped conversion follows it, so the two add up. Sample and settling counts are held in cycles of the fast source and are scaled down when the slow source is active, which keeps wall-clock timing the same on both sources. The analog converter is a counter-based stub: it finishes after a fixed number of cycles and returns a running completion count as its data.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, and while disabled, `res_valid` stays 0 and `res_data` and `res_cfg` read 0.
- R2: On the fast source, an enable write from the disabled state produces its first `res_valid` exactly SETTLE_FAST + 2*SAMPLE_FAST cycles after the write's clock edge (58 with the defaults).
- R3: While enabled and undisturbed, `res_valid` repeats every sample period (SAMPLE_FAST = 8 cycles on the fast source).
- R4: With `clk_src_fast` = 0 (slow source), the settle and sample counts are divided by SLOW_DIV: by default a first result at 21 + 2*4 = 29 cycles and a period of 4.
- R5: A write with `cfg_en` = 1 while converting restarts the conversion and drops the next one, so the next result comes 2 sample periods after the write edge, and none comes between.
- R6: A change of `clk_src_fast` while converting restarts and drops the next conversion in the same way, using the sample period of the new source.
- R7: A write with `cfg_en` = 0 aborts at once. No result appears after its edge, and the next enable pays the full settling delay again.
- R8: A write with `cfg_en` = 1 during the settling delay updates the configuration but neither extends nor restarts the delay.
- R9: `res_data` is the number of conversions the stub has completed since reset, dropped ones included, modulo 2^DATA_W. The first result after reset therefore reads 2.
- R10: `res_valid` is high for exactly one cycle per result.
- R11: `res_cfg` equals the `cfg_sel` value of the most recent write that came before the result's conversion started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_en | input | 1 | Enable bit carried by the write |
| cfg_sel | input | CFG_W | Configuration field carried by the write |
| clk_src_fast | input | 1 | 1 = fast crystal clock source, 0 = slow RC source |
| res_valid | output | 1 | One-cycle strobe for a presented result |
| res_data | output | DATA_W | Result data from the converter stub |
| res_cfg | output | CFG_W | Configuration in force for the result |

## Verification
The bench measures the latency from the write edge to the first strobe on both sources. A design that overlapped the settling delay with the dropped conversion would strobe 8 cycles early. A design that failed to scale by source would give 58 instead of 29. It writes the configuration in the middle of a conversion and switches the clock source while converting. A sequencer that presented the stale conversion would strobe before the two-period mark. A sequencer that did not restart would strobe at an arbitrary offset. It disables and re-enables to catch a design that skips the second settling delay or leaks an aborted result. It writes during settling to catch a design that restarts the delay.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_SETTLE  = 2'd1,
        SEQ_CONVERT = 2'd2
    } seq_state_e;

    // Cycle count on the slow source, rounded up so wall time never shrinks.
    function automatic int unsigned slow_cycles(int unsigned fast_cyc, int unsigned div);
        return (div <= 1) ? fast_cyc : (fast_cyc + div - 1) / div;
    endfunction

endpackage

// File: rtl/adc_seq_timebase.sv
module adc_seq_timebase
    import adc_seq_pkg::*;
#(
    parameter int unsigned SAMPLE_FAST = 8,
    parameter int unsigned SETTLE_FAST = 42,
    parameter int unsigned SLOW_DIV    = 2,
    parameter int unsigned SAMP_W      = 4,
    parameter int unsigned SETTLE_W    = 6
) (
    input  logic                src_fast,
    output logic [SAMP_W-1:0]   sample_cyc,
    output logic [SETTLE_W-1:0] settle_cyc
);
    localparam int unsigned SAMPLE_SLOW = slow_cycles(SAMPLE_FAST, SLOW_DIV);
    localparam int unsigned SETTLE_SLOW = slow_cycles(SETTLE_FAST, SLOW_DIV);

    generate
        if (SLOW_DIV <= 1) begin : g_same
            assign sample_cyc = SAMP_W'(SAMPLE_FAST);
            assign settle_cyc = SETTLE_W'(SETTLE_FAST);
        end else begin : g_scaled
            assign sample_cyc = src_fast ? SAMP_W'(SAMPLE_FAST) : SAMP_W'(SAMPLE_SLOW);
            assign settle_cyc = src_fast ? SETTLE_W'(SETTLE_FAST) : SETTLE_W'(SETTLE_SLOW);
        end
    endgenerate

endmodule

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
    parameter int unsigned SAMP_W = 4,
    parameter int unsigned CFG_W  = 4,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [SAMP_W-1:0] period,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic [CFG_W-1:0]  tag
);
    typedef struct packed {
        logic [SAMP_W-1:0] cnt;
        logic              done;
        logic [DATA_W-1:0] count;
        logic [CFG_W-1:0]  tag;
    } stub_t;

    stub_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!run || restart) begin
            st_d.cnt = period;
        end else if (st_q.cnt <= SAMP_W'(1)) begin
            st_d.done  = 1'b1;
            st_d.cnt   = period;
            st_d.count = st_q.count + 1'b1;
            st_d.tag   = cfg_i;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign data = st_q.count;
    assign tag  = st_q.tag;

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned CFG_W       = 4,
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned SAMPLE_FAST = 8,
    parameter int unsigned SETTLE_FAST = 42,
    parameter int unsigned SLOW_DIV    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [CFG_W-1:0]  cfg_sel,
    input  logic              clk_src_fast,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [CFG_W-1:0]  res_cfg
);
    localparam int unsigned SAMP_W   = $clog2(SAMPLE_FAST + 1);
    localparam int unsigned SETTLE_W = $clog2(SETTLE_FAST + 1);

    typedef struct packed {
        seq_state_e       state;
        logic             discard;
        logic             src;
        logic [CFG_W-1:0] cfg;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [SAMP_W-1:0]   sample_cyc;
    logic [SETTLE_W-1:0] settle_cyc;
    logic                settle_load, settle_clear, settle_done;
    logic                conv_run, conv_restart, conv_done;
    logic [DATA_W-1:0]   conv_data;
    logic [CFG_W-1:0]    conv_tag;
    logic                wr_on, wr_off, src_last, src_change;
    logic                st_settle, st_convert;

    assign wr_on      = cfg_wr && cfg_en;
    assign wr_off     = cfg_wr && !cfg_en;
    assign src_last   = seq_q.src;
    assign src_change = clk_src_fast != src_last;
    assign st_settle  = seq_q.state == SEQ_SETTLE;
    assign st_convert = seq_q.state == SEQ_CONVERT;

    adc_seq_timebase #(
        .SAMPLE_FAST(SAMPLE_FAST), .SETTLE_FAST(SETTLE_FAST), .SLOW_DIV(SLOW_DIV),
        .SAMP_W(SAMP_W), .SETTLE_W(SETTLE_W)
    ) u_timebase (
        .src_fast  (clk_src_fast),
        .sample_cyc(sample_cyc),
        .settle_cyc(settle_cyc)
    );

    adc_seq_settle #(.CNT_W(SETTLE_W)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .clear   (settle_clear),
        .load_val(settle_cyc),
        .expire  (settle_done)
    );

    adc_conv_stub #(.SAMP_W(SAMP_W), .CFG_W(CFG_W), .DATA_W(DATA_W)) u_stub (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (conv_run),
        .restart(conv_restart),
        .period (sample_cyc),
        .cfg_i  (seq_q.cfg),
        .done   (conv_done),
        .data   (conv_data),
        .tag    (conv_tag)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.src    = clk_src_fast;
        settle_load  = 1'b0;
        settle_clear = 1'b0;
        conv_restart = 1'b0;
        conv_run     = st_convert && !wr_off;
        if (cfg_wr) seq_d.cfg = cfg_sel;

        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (wr_on) begin
                    seq_d.state   = SEQ_SETTLE;
                    seq_d.discard = 1'b1;
                    settle_load   = 1'b1;
                end
            end
            SEQ_SETTLE: begin
                if (wr_off) begin
                    seq_d.state  = SEQ_IDLE;
                    settle_clear = 1'b1;
                end else if (settle_done) begin
                    seq_d.state = SEQ_CONVERT;
                end
            end
            SEQ_CONVERT: begin
                if (wr_off) begin
                    seq_d.state   = SEQ_IDLE;
                    seq_d.discard = 1'b0;
                end else if (wr_on || src_change) begin
                    conv_restart  = 1'b1;
                    seq_d.discard = 1'b1;
                end else if (conv_done && seq_q.discard) begin
                    seq_d.discard = 1'b0;
                end
            end
            default: begin
                seq_d.state = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= SEQ_IDLE;
            seq_q.src   <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign res_valid = conv_done && !seq_q.discard && st_convert;
    assign res_data  = conv_data;
    assign res_cfg   = conv_tag;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic cfg_en,
    input logic src_now,
    input logic src_prev,
    input logic in_settle,
    input logic in_convert,
    input logic res_valid
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_settle && !in_convert) |-> !res_valid);

    assert_settle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_settle |-> !res_valid);

    assert_cfg_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_convert && cfg_wr && cfg_en) |=> !res_valid);

    assert_src_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_convert && (src_now != src_prev)) |=> !res_valid);

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_en) |=> (!res_valid && !in_convert && !in_settle));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

bind adc_conv_sequencer adc_seq_checker u_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_en    (cfg_en),
    .src_now   (clk_src_fast),
    .src_prev  (src_last),
    .in_settle (st_settle),
    .in_convert(st_convert),
    .res_valid (res_valid)
);

// File: tb/tb_adc_conv_sequencer.sv
module tb_adc_conv_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_en = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic        clk_src_fast = 1'b1;
    logic        res_valid;
    logic [11:0] res_data;
    logic [3:0]  res_cfg;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    adc_conv_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_sel(cfg_sel), .clk_src_fast(clk_src_fast),
        .res_valid(res_valid), .res_data(res_data), .res_cfg(res_cfg)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Vector: [20] source, [19:16] config, [15:8] first latency, [7:0] period
    localparam logic [20:0] VEC [3] = '{
        {1'b1, 4'h3, 8'd58, 8'd8},
        {1'b0, 4'h5, 8'd29, 8'd4},
        {1'b1, 4'hF, 8'd58, 8'd8}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic src);
        @(negedge clk);
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_en = 1'b0; cfg_sel = '0; clk_src_fast = src;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called just after a negedge; returns the cycle stamp of the write edge.
    task automatic write_cfg(input logic en, input logic [3:0] sel, output int t0);
        cfg_wr = 1'b1; cfg_en = en; cfg_sel = sel;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        t0 = cyc;
    endtask

    task automatic set_src(input logic v, output int t0);
        clk_src_fast = v;
        @(posedge clk);
        @(negedge clk);
        t0 = cyc;
    endtask

    task automatic wait_valid(output int t);
        t = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (res_valid) begin
                t = cyc;
                break;
            end
        end
        if (t < 0) check(1'b0, "timeout waiting for res_valid", 0, 1);
    endtask

    task automatic quiet_for(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (res_valid) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1, t2;

        // R1: reset state and quiet while disabled
        do_reset(1'b1);
        check(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
        check(res_data == 12'd0, "R1 res_data after reset", res_data, 0);
        check(res_cfg == 4'd0, "R1 res_cfg after reset", res_cfg, 0);
        quiet_for(100, "R1 no result while disabled");

        // Vector loop: R2/R4 first latency, R3 period, R9 data, R10 pulse, R11 tag
        for (int v = 0; v < 3; v++) begin
            do_reset(VEC[v][20]);
            write_cfg(1'b1, VEC[v][19:16], t0);
            wait_valid(t1);
            check((t1 - t0) == int'(VEC[v][15:8]),
                  VEC[v][20] ? "R2 first latency fast source" : "R4 first latency slow source",
                  t1 - t0, int'(VEC[v][15:8]));
            check(res_data == 12'd2, "R9 first result data", res_data, 2);
            check(res_cfg == VEC[v][19:16], "R11 result config tag", res_cfg, int'(VEC[v][19:16]));
            @(negedge clk);
            check(res_valid == 1'b0, "R10 strobe lasts one cycle", res_valid, 0);
            t2 = t1;
            for (int k = 0; k < 4; k++) begin
                wait_valid(t1);
                check((t1 - t2) == int'(VEC[v][7:0]),
                      VEC[v][20] ? "R3 back-to-back period" : "R4 slow period",
                      t1 - t2, int'(VEC[v][7:0]));
                t2 = t1;
            end
            check(res_data == 12'd6, "R9 data counts conversions", res_data, 6);
        end

        // R5: configuration write while converting
        do_reset(1'b1);
        write_cfg(1'b1, 4'h1, t0);
        wait_valid(t1);
        repeat (3) @(negedge clk);
        write_cfg(1'b1, 4'hA, t0);
        wait_valid(t1);
        check((t1 - t0) == 16, "R5 latency after config write", t1 - t0, 16);
        check(res_cfg == 4'hA, "R11 tag follows new config", res_cfg, 10);
        wait_valid(t2);
        check((t2 - t1) == 8, "R5 period resumes after discard", t2 - t1, 8);

        // R6: clock source switches while converting
        repeat (2) @(negedge clk);
        set_src(1'b0, t0);
        wait_valid(t1);
        check((t1 - t0) == 8, "R6 latency after switch to slow", t1 - t0, 8);
        wait_valid(t2);
        check((t2 - t1) == 4, "R6 slow period after switch", t2 - t1, 4);
        @(negedge clk);
        set_src(1'b1, t0);
        wait_valid(t1);
        check((t1 - t0) == 16, "R6 latency after switch to fast", t1 - t0, 16);

        // R7: disable aborts, re-enable repays settling
        repeat (5) @(negedge clk);
        write_cfg(1'b0, 4'h2, t0);
        quiet_for(80, "R7 no result after disable");
        write_cfg(1'b1, 4'h2, t0);
        wait_valid(t1);
        check((t1 - t0) == 58, "R7 settling repaid on re-enable", t1 - t0, 58);

        // R7: disable during settling then enable
        write_cfg(1'b0, 4'h2, t0);
        @(negedge clk);
        write_cfg(1'b1, 4'h4, t0);
        repeat (20) @(negedge clk);
        write_cfg(1'b0, 4'h4, t2);
        quiet_for(80, "R7 abort during settling");

        // R8: write during settling does not extend the delay
        write_cfg(1'b1, 4'h6, t0);
        repeat (9) @(negedge clk);
        write_cfg(1'b1, 4'h9, t2);
        wait_valid(t1);
        check((t1 - t0) == 58, "R8 settling not extended", t1 - t0, 58);
        check(res_cfg == 4'h9, "R8 config updated during settling", res_cfg, 9);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule